// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the device side of a two-wire management bus. It watches a management clock and a bidirectional data line, both sampled in the system clock domain. From the line it decodes a frame: a run of idle ones, a two-bit start pattern, a two-bit operation code, a five-bit device address, a five-bit register address, a two-bit turnaround and sixteen data bits. Frames whose device address equals the configured address reach a parallel register port. Reads fetch one register word and shift it out, and writes deliver one word once the frame is complete.

The line is driven only during the data phase of a read. The output enable is high from the end of the turnaround until the sixteenth data clock. A read aimed at another device address still answers, with all ones, and does not touch the register port. The bus clock cannot be stalled, so the register port has no back-pressure. `rd_data_i` must be a combinational function of `reg_addr_o`, valid in the cycle where `rd_req_o` is high. A write pulse must be accepted in the cycle where it appears.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is active and in the first cycle after it, `mdio_oe`, `rd_req_o` and `wr_req_o` are low.
- R2: A frame is not recognised unless at least 32 rising management clock edges precede its first start bit (a 0). A read frame after only 20 ones produces no register request and no driving.
- R3: A read frame (operation bits 1 then 0) to the configured address gives one `rd_req_o` pulse at the end of the turnaround, with `reg_addr_o` equal to the register field. The fetched word is then placed on `mdio_o`, most significant bit first, one bit after each falling management clock edge, for 16 bits.
- R4: A write frame (operation bits 0 then 1) to the configured address gives exactly one `wr_req_o` pulse, carrying the 16 data bits (first received bit is bit 15) on `wr_data_o` and the register field on `reg_addr_o`. The pulse comes only after the 16th data bit has been sampled.
- R5: A read frame to any other device address drives 0xFFFF and raises no `rd_req_o`.
- R6: A write frame to any other device address raises no `wr_req_o` and leaves the register contents unchanged.
- R7: A low value sampled on the second start bit gives a one-cycle `start_warn_o` pulse, and the frame is still decoded.
- R8: Operation codes 00 and 11 raise no register request and never enable the driver.
- R9: Exactly 32 preamble ones before the start bit are enough for a frame to be accepted.
- R10: `mdio_oe` stays low through the header and the turnaround, stays high for all 16 data bits of a read, and is low again after the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the bus, asynchronous |
| mdio_i | input | 1 | Management data line as seen at the pad |
| dev_addr_i | input | 5 | Device address this slave answers to |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Driver enable for the data line |
| start_warn_o | output | 1 | One-cycle pulse: second start bit was low |
| reg_addr_o | output | 5 | Register field of the current frame |
| rd_req_o | output | 1 | One-cycle read strobe to the register model |
| rd_data_i | input | 16 | Register word for `reg_addr_o`, combinational |
| wr_req_o | output | 1 | One-cycle write strobe to the register model |
| wr_data_o | output | 16 | Write word, valid with `wr_req_o` |

## Verification
On every cycle, the assertions check that each read and write strobe lasts exactly one cycle and that the two never coincide with the wrong driver state. A read strobe must be followed by driving, a write strobe must arrive with the driver off, the warning must be a single pulse, and all three outputs must be quiet out of reset. The bench scenarios are needed for everything else: the preamble threshold (20 ones rejected, 32 accepted), the bit order and values shifted out on reads, the all-ones answer for a foreign address, ignored writes and odd opcodes checked by reading back, and the timing of the driver window against the bus clock.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_OPCODE,
    PH_DEVADR,
    PH_REGADR,
    PH_TURN,
    PH_DATA
  } phase_t;

  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam int OPC_BITS  = 2;
  localparam int TURN_BITS = 2;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slave_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_MIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_s,
  input  logic              sdi,
  output logic [1:0]        opc_o,
  output logic [ADDR_W-1:0] dev_o,
  output logic [ADDR_W-1:0] reg_o,
  output logic              start_warn_o,
  output logic              turn_done_o,
  output logic              data_rise_o,
  output logic              data_fall_o,
  output logic              frame_end_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int PRE_W = $clog2(PRE_MIN + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [PRE_W-1:0]  pre_cnt;
  logic              mdc_q;
  logic              rise, fall, last_bit;

  assign rise = mdc_s & ~mdc_q;
  assign fall = ~mdc_s & mdc_q;

  always_comb begin
    case (phase)
      PH_OPCODE: last_bit = (bit_cnt == CNT_W'(OPC_BITS - 1));
      PH_DEVADR: last_bit = (bit_cnt == CNT_W'(ADDR_W - 1));
      PH_REGADR: last_bit = (bit_cnt == CNT_W'(ADDR_W - 1));
      PH_TURN:   last_bit = (bit_cnt == CNT_W'(TURN_BITS - 1));
      PH_DATA:   last_bit = (bit_cnt == CNT_W'(DATA_W - 1));
      default:   last_bit = 1'b1;
    endcase
  end

  assign turn_done_o = rise && (phase == PH_TURN) && last_bit;
  assign data_rise_o = rise && (phase == PH_DATA);
  assign data_fall_o = fall && (phase == PH_DATA);
  assign frame_end_o = data_rise_o && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      bit_cnt      <= '0;
      pre_cnt      <= '0;
      mdc_q        <= 1'b0;
      opc_o        <= '0;
      dev_o        <= '0;
      reg_o        <= '0;
      start_warn_o <= 1'b0;
    end else begin
      mdc_q        <= mdc_s;
      start_warn_o <= 1'b0;
      if (rise) begin
        if (phase != PH_IDLE && phase != PH_START)
          bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        case (phase)
          PH_IDLE: begin
            if (pre_cnt == PRE_W'(PRE_MIN) && !sdi) begin
              phase   <= PH_START;
              pre_cnt <= '0;
            end else if (pre_cnt != PRE_W'(PRE_MIN)) begin
              pre_cnt <= pre_cnt + 1'b1;
            end
          end
          PH_START: begin
            start_warn_o <= ~sdi;
            bit_cnt      <= '0;
            phase        <= PH_OPCODE;
          end
          PH_OPCODE: begin
            opc_o <= {opc_o[0], sdi};
            if (last_bit) phase <= PH_DEVADR;
          end
          PH_DEVADR: begin
            dev_o <= {dev_o[ADDR_W-2:0], sdi};
            if (last_bit) phase <= PH_REGADR;
          end
          PH_REGADR: begin
            reg_o <= {reg_o[ADDR_W-2:0], sdi};
            if (last_bit) phase <= PH_TURN;
          end
          PH_TURN: if (last_bit) phase <= PH_DATA;
          PH_DATA: if (last_bit) phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_data_path.sv
module mdio_data_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              turn_done,
  input  logic              data_rise,
  input  logic              data_fall,
  input  logic              frame_end,
  input  logic              sdi,
  input  logic              is_read,
  input  logic              is_write,
  input  logic              dev_match,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [DATA_W-1:0] shift_q;

  assign rd_req_o = turn_done && is_read && dev_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      mdio_o    <= 1'b0;
      mdio_oe   <= 1'b0;
      wr_req_o  <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_req_o <= 1'b0;
      if (turn_done && is_read) begin
        shift_q <= dev_match ? rd_data_i : '1;
        mdio_oe <= 1'b1;
        mdio_o  <= 1'b0;
      end else if (data_fall && mdio_oe) begin
        mdio_o  <= shift_q[DATA_W-1];
        shift_q <= {shift_q[DATA_W-2:0], 1'b0};
      end else if (data_rise) begin
        if (!mdio_oe) shift_q <= {shift_q[DATA_W-2:0], sdi};
        if (frame_end) begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
          if (is_write && dev_match && !mdio_oe) begin
            wr_req_o  <= 1'b1;
            wr_data_o <= {shift_q[DATA_W-2:0], sdi};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_MIN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_i,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              start_warn_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              rd_req_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [1:0]        bus_s;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] dev_field;
  logic              turn_done, data_rise, data_fall, frame_end;

  mdio_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b01)) i_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({mdc_i, mdio_i}),
    .q   (bus_s)
  );

  mdio_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_MIN(PRE_MIN)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .mdc_s        (bus_s[1]),
    .sdi          (bus_s[0]),
    .opc_o        (opc),
    .dev_o        (dev_field),
    .reg_o        (reg_addr_o),
    .start_warn_o (start_warn_o),
    .turn_done_o  (turn_done),
    .data_rise_o  (data_rise),
    .data_fall_o  (data_fall),
    .frame_end_o  (frame_end)
  );

  mdio_data_path #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .turn_done (turn_done),
    .data_rise (data_rise),
    .data_fall (data_fall),
    .frame_end (frame_end),
    .sdi       (bus_s[0]),
    .is_read   (opc == OPC_READ),
    .is_write  (opc == OPC_WRITE),
    .dev_match (dev_field == dev_addr_i),
    .rd_data_i (rd_data_i),
    .rd_req_o  (rd_req_o),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .wr_req_o  (wr_req_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/mdio_slave_checker.sv
module mdio_slave_checker (
  input logic clk,
  input logic rst_n,
  input logic mdio_oe,
  input logic rd_req,
  input logic wr_req,
  input logic start_warn
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!mdio_oe && !rd_req && !wr_req));

  a_r3_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r3_rd_then_drive: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> mdio_oe);

  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  a_r4_wr_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !mdio_oe);

  a_r7_warn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_warn |=> !start_warn);

  a_r10_drive_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !wr_req);
endmodule

bind mdio_mgmt_slave mdio_slave_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mdio_oe    (mdio_oe),
  .rd_req     (rd_req_o),
  .wr_req     (wr_req_o),
  .start_warn (start_warn_o)
);

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;
  localparam int         HALF = 6;
  localparam logic [4:0] DEV  = 5'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        drv = 1'b1;
  logic        mdio_line, mdio_o, mdio_oe, warn, rd_req, wr_req;
  logic [4:0]  reg_addr;
  logic [15:0] rd_data, wr_data;
  logic [15:0] dev_regs [32];
  logic [15:0] exp_regs [32];

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, warn_cnt = 0, oe_cycles = 0;
  logic [4:0]  last_wr_addr = '0, last_rd_addr = '0;
  logic [15:0] last_wr_data = '0;
  bit          finished = 0;

  always #4 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : drv;
  assign rd_data   = dev_regs[reg_addr];

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .clk (clk), .rst_n (rst_n), .mdc_i (mdc), .mdio_i (mdio_line),
    .dev_addr_i (DEV), .mdio_o (mdio_o), .mdio_oe (mdio_oe),
    .start_warn_o (warn), .reg_addr_o (reg_addr), .rd_req_o (rd_req),
    .rd_data_i (rd_data), .wr_req_o (wr_req), .wr_data_o (wr_data)
  );

  function automatic logic [15:0] init_val(input int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) dev_regs[i] = init_val(i);
    end else begin
      if (wr_req) begin
        wr_cnt++;
        last_wr_addr = reg_addr;
        last_wr_data = wr_data;
        dev_regs[reg_addr] = wr_data;
      end
      if (rd_req) begin
        rd_cnt++;
        last_rd_addr = reg_addr;
      end
      if (warn) warn_cnt++;
      if (mdio_oe) oe_cycles++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    mdc = 1'b0; drv = b; tick(HALF);
    mdc = 1'b1; tick(HALF);
  endtask

  // One frame; returns sampled read word, whether the driver was seen early,
  // whether a gap appeared during the read data, and wr count before the last bit.
  task automatic frame(input int pre, input logic st2, input logic [1:0] op,
                       input logic [4:0] dev, input logic [4:0] rg,
                       input logic [15:0] wd, output logic [15:0] rv,
                       output bit oe_early, output bit oe_gap, output int wr_snap);
    bit reading;
    reading  = (op == 2'b10);
    rv       = '0;
    oe_early = 0;
    oe_gap   = 0;
    wr_snap  = 0;
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(st2);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(dev[i]);
    for (int i = 4; i >= 0; i--) send_bit(rg[i]);
    for (int i = 0; i < 2; i++) begin
      mdc = 1'b0; drv = reading ? 1'b1 : (i == 0); tick(HALF);
      if (mdio_oe) oe_early = 1;
      mdc = 1'b1; tick(HALF);
    end
    for (int i = 0; i < 16; i++) begin
      mdc = 1'b0; drv = reading ? 1'b1 : wd[15-i]; tick(HALF);
      rv = {rv[14:0], mdio_line};
      if (!mdio_oe) oe_gap = 1;
      if (i == 15) wr_snap = wr_cnt;
      mdc = 1'b1; tick(HALF);
    end
    drv = 1'b1;
    tick(HALF);
  endtask

  initial begin
    logic [15:0] rv;
    bit          early, gap;
    int          snap, w0, r0, o0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) exp_regs[i] = init_val(i);

    tick(3);
    check(!mdio_oe && !rd_req && !wr_req, "R1", "outputs in reset", mdio_oe, 0);
    rst_n = 1'b1;
    tick(1);
    check(!mdio_oe && !rd_req && !wr_req, "R1", "outputs after reset", mdio_oe, 0);

    // R9: exactly 32 preamble ones, write to register 4
    w0 = wr_cnt;
    frame(32, 1'b1, 2'b01, DEV, 5'd4, 16'hA5C3, rv, early, gap, snap);
    exp_regs[4] = 16'hA5C3;
    check(wr_cnt == w0 + 1, "R9", "write accepted with 32 ones", wr_cnt - w0, 1);
    check(snap == w0, "R4", "no write before last bit", snap - w0, 0);
    check(last_wr_addr == 5'd4, "R4", "write address", last_wr_addr, 4);
    check(last_wr_data == 16'hA5C3, "R4", "write data", last_wr_data, 16'hA5C3);
    check(!mdio_oe, "R10", "no drive after write", mdio_oe, 0);

    // R3 / R10: read back register 4
    r0 = rd_cnt;
    frame(34, 1'b1, 2'b10, DEV, 5'd4, 16'h0, rv, early, gap, snap);
    check(rv == 16'hA5C3, "R3", "read data", rv, 16'hA5C3);
    check(rd_cnt == r0 + 1, "R3", "read strobe count", rd_cnt - r0, 1);
    check(last_rd_addr == 5'd4, "R3", "read address", last_rd_addr, 4);
    check(!early, "R10", "driver off in header/turnaround", early, 0);
    check(!gap, "R10", "driver on for all data bits", gap, 0);
    check(!mdio_oe, "R10", "driver off after frame", mdio_oe, 0);

    // R5: read to a foreign address
    r0 = rd_cnt;
    frame(34, 1'b1, 2'b10, DEV ^ 5'd1, 5'd4, 16'h0, rv, early, gap, snap);
    check(rv == 16'hFFFF, "R5", "foreign read value", rv, 16'hFFFF);
    check(rd_cnt == r0, "R5", "no read strobe", rd_cnt - r0, 0);

    // R6: write to a foreign address, then read back
    w0 = wr_cnt;
    frame(34, 1'b1, 2'b01, DEV ^ 5'd2, 5'd7, 16'h1357, rv, early, gap, snap);
    check(wr_cnt == w0, "R6", "no write strobe", wr_cnt - w0, 0);
    frame(34, 1'b1, 2'b10, DEV, 5'd7, 16'h0, rv, early, gap, snap);
    check(rv == exp_regs[7], "R6", "register unchanged", rv, exp_regs[7]);

    // R2: short preamble read gets no response (register 3 keeps the line high)
    r0 = rd_cnt; o0 = oe_cycles;
    frame(20, 1'b1, 2'b10, DEV, 5'd3, 16'h0, rv, early, gap, snap);
    check(rd_cnt == r0, "R2", "short preamble read strobe", rd_cnt - r0, 0);
    check(oe_cycles == o0, "R2", "short preamble driving", oe_cycles - o0, 0);

    // R7: bad second start bit still decodes
    w0 = wr_cnt; o0 = warn_cnt;
    frame(40, 1'b0, 2'b01, DEV, 5'd12, 16'h4C2E, rv, early, gap, snap);
    exp_regs[12] = 16'h4C2E;
    check(warn_cnt == o0 + 1, "R7", "warning pulses", warn_cnt - o0, 1);
    check(wr_cnt == w0 + 1 && last_wr_data == 16'h4C2E, "R7", "frame still written",
          last_wr_data, 16'h4C2E);

    // R8: opcodes 00 and 11
    for (int k = 0; k < 2; k++) begin
      w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cycles;
      frame(34, 1'b1, (k == 0) ? 2'b00 : 2'b11, DEV, 5'd5, 16'h0F0F, rv, early, gap, snap);
      check(wr_cnt == w0 && rd_cnt == r0, "R8", "no request for odd opcode",
            wr_cnt - w0 + rd_cnt - r0, 0);
      check(oe_cycles == o0, "R8", "no driving for odd opcode", oe_cycles - o0, 0);
    end
    frame(34, 1'b1, 2'b10, DEV, 5'd5, 16'h0, rv, early, gap, snap);
    check(rv == exp_regs[5], "R8", "register 5 unchanged", rv, exp_regs[5]);

    // Random mix of reads and writes
    for (int k = 0; k < 40; k++) begin
      logic [4:0]  rg, dv;
      logic [15:0] wd;
      bit          rd;
      rd = ($urandom % 2) == 0;
      rg = 5'($urandom % 32);
      dv = (($urandom % 4) == 0) ? (DEV ^ 5'd3) : DEV;
      wd = 16'($urandom);
      w0 = wr_cnt;
      frame(32 + int'($urandom % 6), 1'b1, rd ? 2'b10 : 2'b01, dv, rg, wd,
            rv, early, gap, snap);
      if (rd) begin
        check(rv == ((dv == DEV) ? exp_regs[rg] : 16'hFFFF), (dv == DEV) ? "R3" : "R5",
              "random read", rv, (dv == DEV) ? exp_regs[rg] : 16'hFFFF);
      end else if (dv == DEV) begin
        exp_regs[rg] = wd;
        check(wr_cnt == w0 + 1 && last_wr_data == wd && last_wr_addr == rg, "R4",
              "random write", last_wr_data, wd);
      end else begin
        check(wr_cnt == w0, "R6", "random foreign write", wr_cnt - w0, 0);
      end
    end
    report();
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule